// File: doc/BRIEF.md
# Gated SMI Request Controller

This block gathers power-management interrupt requests from seven sources and drives one active-low SMI line to the processor. The sources are a periodic poll event, an idle-timer expiry, a software write to a command port, a software request register, an external request pin, a suspend button and a battery-low input. The poll and idle events arrive as one-cycle pulses. The command-port and software-request events are one-cycle pulses made inside the block from register writes. The three pin inputs are asynchronous and active-low.

Each source has a sticky status bit that records its request. A source can set that bit only when three enables are all 1: its own enable, its group enable if it belongs to a group, and the global enable. The SMI line is driven from the status bits through a software gate bit. Software can drop the gate to negate the line and raise it again to re-arm the line while requests are still pending. A single-cycle register port gives access to the control fields, the per-source enables and the status bits.

Top module: `smi_req_ctrl`

## Requirements
- R1: When the global enable (control register, address 0, bit 0) is 0, no status bit becomes 1, whatever the other enables hold.
- R2: A status bit is set only when its individual enable (address 1, bit i), its group enable and the global enable are all 1. Sources 2 and 3 form the software group (address 0, bit 2). Sources 4, 5 and 6 form the pin group (address 0, bit 3). Sources 0 and 1 have no group.
- R3: Writing an enable bit with 1 turns it on and writing it with 0 turns it off. Address 0 reads back {gate at bit 1, global at bit 0, groups at bits 3:2}, and address 1 reads back the individual enables.
- R4: Status (address 2, bit i for source i: 0 poll, 1 idle, 2 command port, 3 software request, 4 external pin, 5 button, 6 battery low) is cleared by writing 0 to a bit. Writing 1 to a bit leaves it unchanged, so a write of all 1s changes nothing.
- R5: If a hardware set and a software clear reach the same status bit in the same cycle, the bit ends at 1.
- R6: smi_n is low exactly while the gate bit (address 0, bit 1) is 1 and at least one status bit is set. It goes high on the edge that writes the gate to 0.
- R7: When the gate goes from 0 back to 1 while a status bit is still set, smi_n goes low again on that same edge.
- R8: Each write to address 3 raises one command-port request (source 2). Each write to address 4 raises one software request (source 3).
- R9: Each pin input passes through a two-flop synchronizer. Its status bit is set on the third rising edge after the pin falls. A pin that stays low does not set the bit again after software clears it.
- R10: After reset all enables, the gate and all status bits read 0, and smi_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_evt | input | 1 | Periodic poll pulse (source 0) |
| idle_evt | input | 1 | Idle-timer expiry pulse (source 1) |
| ext_smi_n | input | 1 | External request pin, active-low, asynchronous (source 4) |
| susp_btn_n | input | 1 | Suspend/resume button, active-low, asynchronous (source 5) |
| batt_low_n | input | 1 | Battery-low input, active-low, asynchronous (source 6) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| smi_n | output | 1 | Active-low SMI output to the processor |

## Verification
The request path is driven with source events under several enable settings, one setting at a time:
- global off with every other enable on, which isolates the global block;
- one group off, which isolates the group gate;
- one individual enable off, which isolates the per-source gate;
- everything on, which shows the normal set.

The gate is cycled from 1 to 0 and back to 1 while a request is pending, which separates a re-armable output from a latched one. A clear and an event are sent to the same bit in the same cycle, which tells set-dominant behaviour from clear-dominant behaviour. Each pin is held low across a status clear, which tells edge detection from level detection.

// File: rtl/smi_pkg.sv
package smi_pkg;
    localparam int NUM_SRC = 7;
    localparam int NUM_GRP = 2;

    localparam int SRC_POLL = 0;
    localparam int SRC_IDLE = 1;
    localparam int SRC_CMD  = 2;
    localparam int SRC_SWRQ = 3;
    localparam int SRC_EXT  = 4;
    localparam int SRC_BTN  = 5;
    localparam int SRC_BATT = 6;

    localparam logic [NUM_SRC-1:0] GRP_SW_MASK  = 7'b0001100;
    localparam logic [NUM_SRC-1:0] GRP_PIN_MASK = 7'b1110000;

    localparam logic [2:0] ADR_CTRL  = 3'd0;
    localparam logic [2:0] ADR_EN    = 3'd1;
    localparam logic [2:0] ADR_STAT  = 3'd2;
    localparam logic [2:0] ADR_CMD   = 3'd3;
    localparam logic [2:0] ADR_SWREQ = 3'd4;

    localparam int CB_GLOB = 0;
    localparam int CB_GATE = 1;
    localparam int CB_GSW  = 2;
    localparam int CB_GPIN = 3;
endpackage

// File: rtl/smi_pin_edge.sv
module smi_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } edge_t;

    edge_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[STAGES-2:0], pin_n};
        d.prev = q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign fall = q.prev & ~q.sync[STAGES-1];
endmodule

// File: rtl/smi_src_gate.sv
module smi_src_gate
    import smi_pkg::*;
(
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_GRP-1:0] grp_en,
    input  logic               glob_en,
    output logic [NUM_SRC-1:0] set_vec
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic grp_ok;
        if (GRP_SW_MASK[i]) begin : g_sw
            assign grp_ok = grp_en[0];
        end else if (GRP_PIN_MASK[i]) begin : g_pin
            assign grp_ok = grp_en[1];
        end else begin : g_none
            assign grp_ok = 1'b1;
        end
        assign set_vec[i] = evt[i] & src_en[i] & grp_ok & glob_en;
    end
endmodule

// File: rtl/smi_req_ctrl.sv
module smi_req_ctrl
    import smi_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_evt,
    input  logic              idle_evt,
    input  logic              ext_smi_n,
    input  logic              susp_btn_n,
    input  logic              batt_low_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              smi_n
);
    localparam int NUM_PIN = 3;

    typedef struct packed {
        logic               glob;
        logic               gate;
        logic [NUM_GRP-1:0] grp;
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] stat;
        logic               smi_n;
    } state_t;

    state_t q, d;

    logic [NUM_PIN-1:0] pin_raw, pin_fall;
    logic [NUM_SRC-1:0] evt, set_vec;
    logic               wr_ctrl, wr_en, wr_stat, wr_cmd, wr_swrq;

    assign pin_raw = {batt_low_n, susp_btn_n, ext_smi_n};

    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
        smi_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin_n(pin_raw[p]),
            .fall (pin_fall[p])
        );
    end

    assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(ADR_CTRL));
    assign wr_en   = reg_we && (reg_addr == ADDR_W'(ADR_EN));
    assign wr_stat = reg_we && (reg_addr == ADDR_W'(ADR_STAT));
    assign wr_cmd  = reg_we && (reg_addr == ADDR_W'(ADR_CMD));
    assign wr_swrq = reg_we && (reg_addr == ADDR_W'(ADR_SWREQ));

    always_comb begin
        evt           = '0;
        evt[SRC_POLL] = poll_evt;
        evt[SRC_IDLE] = idle_evt;
        evt[SRC_CMD]  = wr_cmd;
        evt[SRC_SWRQ] = wr_swrq;
        evt[SRC_EXT]  = pin_fall[0];
        evt[SRC_BTN]  = pin_fall[1];
        evt[SRC_BATT] = pin_fall[2];
    end

    smi_src_gate u_gate (
        .evt    (evt),
        .src_en (q.en),
        .grp_en (q.grp),
        .glob_en(q.glob),
        .set_vec(set_vec)
    );

    always_comb begin
        d = q;
        if (wr_ctrl) begin
            d.glob = reg_wdata[CB_GLOB];
            d.gate = reg_wdata[CB_GATE];
            d.grp  = {reg_wdata[CB_GPIN], reg_wdata[CB_GSW]};
        end
        if (wr_en) d.en = reg_wdata[NUM_SRC-1:0];
        if (wr_stat) d.stat = q.stat & reg_wdata[NUM_SRC-1:0];
        d.stat  = d.stat | set_vec;
        d.smi_n = ~(d.gate & (|d.stat));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.smi_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(ADR_CTRL): begin
                reg_rdata[CB_GLOB] = q.glob;
                reg_rdata[CB_GATE] = q.gate;
                reg_rdata[CB_GSW]  = q.grp[0];
                reg_rdata[CB_GPIN] = q.grp[1];
            end
            ADDR_W'(ADR_EN):   reg_rdata[NUM_SRC-1:0] = q.en;
            ADDR_W'(ADR_STAT): reg_rdata[NUM_SRC-1:0] = q.stat;
            default:           reg_rdata = '0;
        endcase
    end

    assign smi_n = q.smi_n;

    logic               glob_q;
    logic [NUM_SRC-1:0] en_q, stat_q;
    assign glob_q = q.glob;
    assign en_q   = q.en;
    assign stat_q = q.stat;
endmodule

module smi_req_ctrl_chk
    import smi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic               smi_n,
    input logic               glob_q,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] stat_q,
    input logic [NUM_SRC-1:0] set_vec
);
    logic is_ctrl, is_stat;
    assign is_ctrl = reg_we && (reg_addr == ADDR_W'(ADR_CTRL));
    assign is_stat = reg_we && (reg_addr == ADDR_W'(ADR_STAT));

    p_global_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_q |=> ((stat_q & ~$past(stat_q)) == '0));

    p_need_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

    p_ones_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_stat && (reg_wdata[NUM_SRC-1:0] == '1)) |=> (($past(stat_q) & ~stat_q) == '0));

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

    p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl && !reg_wdata[CB_GATE]) |=> smi_n);

    p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl && reg_wdata[CB_GATE] && (|stat_q)) |=> !smi_n);
endmodule

bind smi_req_ctrl smi_req_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .smi_n    (smi_n),
    .glob_q   (glob_q),
    .en_q     (en_q),
    .stat_q   (stat_q),
    .set_vec  (set_vec)
);

// File: tb/smi_req_ctrl_tb.sv
module smi_req_ctrl_tb;
    localparam int DW = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          poll_evt = 1'b0, idle_evt = 1'b0;
    logic          ext_smi_n = 1'b1, susp_btn_n = 1'b1, batt_low_n = 1'b1;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          smi_n;

    always #2 clk = ~clk;

    smi_req_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .poll_evt(poll_evt), .idle_evt(idle_evt),
        .ext_smi_n(ext_smi_n), .susp_btn_n(susp_btn_n), .batt_low_n(batt_low_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .smi_n(smi_n)
    );

    typedef struct {
        bit          is_smi;
        logic [7:0]  exp;
        string       req;
    } item_t;

    item_t sb[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            wait (sb.size() > 0);
            begin
                item_t it;
                logic [7:0] act;
                it  = sb.pop_front();
                act = it.is_smi ? {7'd0, smi_n} : reg_rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string req);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        #1;
        it.is_smi = 1'b0; it.exp = e; it.req = req;
        sb.push_back(it);
    endtask

    task automatic chk_smi(input logic e, input string req);
        item_t it;
        @(negedge clk);
        #1;
        it.is_smi = 1'b1; it.exp = {7'd0, e}; it.req = req;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic pulse_poll();
        @(negedge clk); poll_evt = 1'b1;
        @(posedge clk); #1; poll_evt = 1'b0;
    endtask

    task automatic pulse_idle();
        @(negedge clk); idle_evt = 1'b1;
        @(posedge clk); #1; idle_evt = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        #10;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        chk_smi(1'b1, "R10 smi_n after reset");
        rd(3'd0, 8'h00, "R10 control after reset");
        rd(3'd1, 8'h00, "R10 enables after reset");
        rd(3'd2, 8'h00, "R10 status after reset");

        // R3 enable write/readback; R1 global off blocks
        wr(3'd1, 8'h7F);
        wr(3'd0, 8'h0C);
        rd(3'd1, 8'h7F, "R3 enables readback");
        rd(3'd0, 8'h0C, "R3 control readback");
        pulse_poll();
        rd(3'd2, 8'h00, "R1 poll blocked by global");
        wr(3'd3, 8'h00);
        rd(3'd2, 8'h00, "R1 cmd port blocked by global");

        // R2 normal set, R6 gate off keeps smi high
        wr(3'd0, 8'h0D);
        pulse_poll();
        rd(3'd2, 8'h01, "R2 poll sets status");
        chk_smi(1'b1, "R6 gate off smi high");
        wr(3'd0, 8'h0F);
        chk_smi(1'b0, "R6 gate on with pending");

        // R4 write all ones keeps status
        wr(3'd2, 8'hFF);
        rd(3'd2, 8'h01, "R4 ones write keeps status");

        // R6 gate off negates, R7 rearm
        wr(3'd0, 8'h0D);
        chk_smi(1'b1, "R6 gate written 0");
        wr(3'd0, 8'h0F);
        chk_smi(1'b0, "R7 rearm with pending");

        // R4 clear by zero
        wr(3'd2, 8'hFE);
        rd(3'd2, 8'h00, "R4 zero clears bit");
        chk_smi(1'b1, "R6 no status smi high");

        // R2 software group off
        wr(3'd0, 8'h0B);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h00);
        rd(3'd2, 8'h00, "R2 software group disabled");

        // R8 software sources
        wr(3'd0, 8'h0F);
        wr(3'd3, 8'h00);
        rd(3'd2, 8'h04, "R8 cmd port write");
        wr(3'd4, 8'h00);
        rd(3'd2, 8'h0C, "R8 software request write");
        chk_smi(1'b0, "R6 software requests assert");
        wr(3'd2, 8'h00);
        rd(3'd2, 8'h00, "R4 clear all");

        // R2 individual enable off
        wr(3'd1, 8'h7D);
        pulse_idle();
        rd(3'd2, 8'h00, "R2 idle individually disabled");
        wr(3'd1, 8'h7F);

        // R5 set beats clear
        pulse_poll();
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h00; idle_evt = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0; idle_evt = 1'b0;
        rd(3'd2, 8'h02, "R5 set wins over clear");
        wr(3'd2, 8'h00);

        // R9 external pin edge timing and level hold
        @(negedge clk); ext_smi_n = 1'b0;
        rd(3'd2, 8'h00, "R9 ext first edge");
        rd(3'd2, 8'h00, "R9 ext second edge");
        rd(3'd2, 8'h10, "R9 ext third edge");
        wr(3'd2, 8'hEF);
        rd(3'd2, 8'h00, "R9 ext held low no reset");
        rd(3'd2, 8'h00, "R9 ext held low later");
        ext_smi_n = 1'b1;

        // R9 button
        @(negedge clk); susp_btn_n = 1'b0;
        rd(3'd2, 8'h00, "R9 button edge 1");
        rd(3'd2, 8'h00, "R9 button edge 2");
        rd(3'd2, 8'h20, "R9 button edge 3");
        susp_btn_n = 1'b1;

        // R9 battery low
        @(negedge clk); batt_low_n = 1'b0;
        rd(3'd2, 8'h20, "R9 battery edge 1");
        rd(3'd2, 8'h20, "R9 battery edge 2");
        rd(3'd2, 8'h60, "R9 battery edge 3");
        chk_smi(1'b0, "R6 pin requests assert");
        batt_low_n = 1'b1;

        wr(3'd2, 8'h00);
        chk_smi(1'b1, "R6 all cleared smi high");

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule